// File: doc/BRIEF.md
# Precharged Opto-Matrix Row Scanner

This block walks a keypad or sensor matrix in which every row line feeds a set of opto-couplers and every column line is read back through a pull-up resistor. A row is selected by pulling its line low. A conducting opto then pulls its column low, and an idle column reads high. The resistor is too weak to lift a column back quickly once an opto has held it low. For that reason the scanner never steps straight from one active row to the next. It first releases every row. It then turns the column pins into outputs and drives them high for a fixed number of cycles. It hands the columns back to input mode for one cycle, and only after that does it pull the next row low.

After each row has been low for a settle interval, the column inputs are captured once into that row's slice of a frame buffer. When the last row has been captured, the whole frame is copied into a snapshot register and a one-cycle done strobe is raised. Scanning then restarts at row 0 for as long as the enable stays high. The snapshot is a plain registered output qualified by the strobe. There is no valid/ready handshake and no back-pressure: a consumer that misses a strobe simply reads the newer frame. Dropping the enable releases the matrix in the same cycle and abandons the partial frame.

Top module: `opto_matrix_scanner`

## Requirements
- R1: While reset is asserted, and right after it, every row output is high (released), the column direction output is low (input), the column drive is all zeros, the done strobe is low and the snapshot is all zeros.
- R2: At most one row output is low in any cycle, and every row output is high in every cycle where the column direction output is high.
- R3: Every row activation follows this sequence. First comes at least one cycle with all rows released and the columns as inputs. Next come exactly PRECHARGE_CYC consecutive cycles with the direction output high and the column drive all ones. Then exactly one cycle follows with all rows released and the direction output low, and the row goes low in the next cycle. A low row output never changes directly into a different low row output.
- R4: A selected row stays low for exactly SETTLE_CYC cycles. Rows are selected in ascending order from 0 to ROWS-1, and the order then wraps to 0.
- R5: The columns are sampled once, at the clock edge that ends the last settle cycle of a row. Snapshot bit r*COLS+c is 1 when column c read low (opto conducting) during row r, and 0 when it read high.
- R6: The done strobe is high for exactly one cycle after the edge that samples row ROWS-1. The snapshot changes only at that same edge, and only then.
- R7: While scan enable is low, all rows are released and the columns are inputs in that same cycle. A frame that is interrupted produces neither a strobe nor a snapshot change. When enable returns, scanning restarts at row 0 with the full release and precharge sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High to run scanning; low releases the matrix at once |
| row_n_o | output | ROWS | Row lines, 0 = selected, 1 = released |
| col_oe_o | output | 1 | Column direction, 1 = pins driven, 0 = pins are inputs |
| col_drive_o | output | COLS | Column drive value, all ones during precharge |
| col_i | input | COLS | Column pin levels read back |
| snap_o | output | ROWS*COLS | Last complete frame, bit r*COLS+c set when that opto conducted |
| frame_done_o | output | 1 | One-cycle strobe marking a new snapshot |

## Verification
The bench models each column as a node that keeps its last level. A conducting opto can pull the node low only after its row has been low for the full settle interval, and only a precharge can lift it again. Under this model, a design that skips or shortens the precharge carries stale lows into the next row. A design that samples one cycle early reads the precharged high instead of the opto. Directed frames cover several corner cases: an all-pressed column, where every row leaves the column low for its successor; the first and last matrix positions, which expose a swapped bit layout; and enable drops in mid-frame, which catch a design that still raises the strobe, updates the snapshot, or resumes at the interrupted row. Random patterns fill the remaining frames.

// File: rtl/opto_scan_pkg.sv
package opto_scan_pkg;

  // Phases of one row step, in the order they are visited.
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_RELEASE = 3'd1,
    PH_PRECH   = 3'd2,
    PH_TURN    = 3'd3,
    PH_ACTIVE  = 3'd4
  } scan_phase_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/opto_scan_sequencer.sv
module opto_scan_sequencer
  import opto_scan_pkg::*;
#(
  parameter int unsigned ROWS          = 4,
  parameter int unsigned PRECHARGE_CYC = 3,
  parameter int unsigned SETTLE_CYC    = 4,
  localparam int unsigned RW   = idx_width(ROWS),
  localparam int unsigned CMAX = (PRECHARGE_CYC > SETTLE_CYC) ? PRECHARGE_CYC : SETTLE_CYC,
  localparam int unsigned CW   = $clog2(CMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  output scan_phase_e   phase_o,
  output logic [RW-1:0] row_sel_o,
  output logic          sample_o,
  output logic          last_row_o
);

  localparam logic [CW-1:0] PRE_LAST = CW'(PRECHARGE_CYC - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  scan_phase_e   phase_q, phase_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign last_row_o = (row_q == ROW_LAST);
  assign sample_o   = scan_en && (phase_q == PH_ACTIVE) && (cnt_q == SET_LAST);

  always_comb begin
    phase_d = phase_q;
    row_d   = row_q;
    cnt_d   = cnt_q;
    if (!scan_en) begin
      phase_d = PH_IDLE;
      row_d   = '0;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_RELEASE;
          row_d   = '0;
          cnt_d   = '0;
        end
        PH_RELEASE: begin
          phase_d = PH_PRECH;
          cnt_d   = '0;
        end
        PH_PRECH: begin
          if (cnt_q == PRE_LAST) begin
            phase_d = PH_TURN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_TURN: begin
          phase_d = PH_ACTIVE;
          cnt_d   = '0;
        end
        PH_ACTIVE: begin
          if (cnt_q == SET_LAST) begin
            phase_d = PH_RELEASE;
            cnt_d   = '0;
            row_d   = last_row_o ? '0 : row_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          row_d   = '0;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      row_q   <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      row_q   <= row_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o   = phase_q;
  assign row_sel_o = row_q;

endmodule

// File: rtl/opto_row_driver.sv
module opto_row_driver #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned RW   = 2
) (
  input  logic            drive_en,
  input  logic [RW-1:0]   row_sel,
  output logic [ROWS-1:0] row_n_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_n_o[r] = !(drive_en && (row_sel == RW'(r)));
  end

endmodule

// File: rtl/opto_col_precharge.sv
module opto_col_precharge #(
  parameter int unsigned COLS = 4
) (
  input  logic            precharge,
  output logic            col_oe_o,
  output logic [COLS-1:0] col_drive_o
);

  assign col_oe_o = precharge;
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_drive_o[c] = precharge;
  end

endmodule

// File: rtl/opto_frame_capture.sv
module opto_frame_capture #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 4,
  parameter int unsigned RW   = 2,
  localparam int unsigned NB  = ROWS * COLS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic          last_row,
  input  logic [RW-1:0] row_sel,
  input  logic [COLS-1:0] col_i,
  output logic [NB-1:0] snap_o,
  output logic          frame_done_o
);

  logic [NB-1:0] line_q;
  logic [NB-1:0] frame_nx;

  // Low column = conducting opto = 1 in the frame.
  for (genvar r = 0; r < ROWS; r++) begin : g_slice
    logic hit;
    assign hit = sample && (row_sel == RW'(r));
    assign frame_nx[r*COLS +: COLS] = hit ? ~col_i : line_q[r*COLS +: COLS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q       <= '0;
      snap_o       <= '0;
      frame_done_o <= 1'b0;
    end else begin
      line_q       <= frame_nx;
      frame_done_o <= sample && last_row;
      if (sample && last_row) snap_o <= frame_nx;
    end
  end

endmodule

// File: rtl/opto_matrix_scanner.sv
module opto_matrix_scanner
  import opto_scan_pkg::*;
#(
  parameter int unsigned ROWS          = 4,
  parameter int unsigned COLS          = 4,
  parameter int unsigned PRECHARGE_CYC = 3,
  parameter int unsigned SETTLE_CYC    = 4,
  localparam int unsigned RW = idx_width(ROWS),
  localparam int unsigned NB = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_en,
  output logic [ROWS-1:0] row_n_o,
  output logic            col_oe_o,
  output logic [COLS-1:0] col_drive_o,
  input  logic [COLS-1:0] col_i,
  output logic [NB-1:0]   snap_o,
  output logic            frame_done_o
);

  scan_phase_e   phase;
  logic [RW-1:0] row_sel;
  logic          sample;
  logic          last_row;
  logic          row_drive_en;
  logic          precharge;

  opto_scan_sequencer #(
    .ROWS(ROWS), .PRECHARGE_CYC(PRECHARGE_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en),
    .phase_o(phase), .row_sel_o(row_sel),
    .sample_o(sample), .last_row_o(last_row)
  );

  // Enable gates the pins directly so a drop releases the matrix at once.
  assign row_drive_en = scan_en && (phase == PH_ACTIVE);
  assign precharge    = scan_en && (phase == PH_PRECH);

  opto_row_driver #(.ROWS(ROWS), .RW(RW)) u_rows (
    .drive_en(row_drive_en), .row_sel(row_sel), .row_n_o(row_n_o)
  );

  opto_col_precharge #(.COLS(COLS)) u_cols (
    .precharge(precharge), .col_oe_o(col_oe_o), .col_drive_o(col_drive_o)
  );

  opto_frame_capture #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample(sample), .last_row(last_row),
    .row_sel(row_sel), .col_i(col_i),
    .snap_o(snap_o), .frame_done_o(frame_done_o)
  );

endmodule

// File: rtl/opto_scan_checker.sv
module opto_scan_checker #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 4,
  localparam int unsigned NB  = ROWS * COLS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_en,
  input logic [ROWS-1:0] row_n_o,
  input logic            col_oe_o,
  input logic [COLS-1:0] col_drive_o,
  input logic [NB-1:0]   snap_o,
  input logic            frame_done_o
);

  p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_n_o) <= 1);

  p_oe_rows_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_oe_o |-> (&row_n_o));

  p_drive_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_oe_o |-> (&col_drive_o));

  p_turn_before_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(~row_n_o)) && (&$past(row_n_o))) |-> !$past(col_oe_o));

  p_no_row_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~row_n_o)) |=> ((row_n_o == $past(row_n_o)) || (&row_n_o)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_o |-> $stable(snap_o));

  p_idle_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> ((&row_n_o) && !col_oe_o));

  always_comb begin
    if (!rst_n) begin
      a_reset_free_r1: assert ((&row_n_o) && !col_oe_o);
    end
  end

endmodule

bind opto_matrix_scanner opto_scan_checker #(.ROWS(ROWS), .COLS(COLS)) u_scan_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .row_n_o(row_n_o),
  .col_oe_o(col_oe_o), .col_drive_o(col_drive_o), .snap_o(snap_o),
  .frame_done_o(frame_done_o)
);

// File: tb/opto_matrix_scanner_test.sv
`timescale 1ns/1ps
module opto_matrix_scanner_test;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int PRE  = 3;
  localparam int SET  = 4;
  localparam int NB   = ROWS * COLS;
  localparam int FRAMES_WANTED = 40;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            scan_en;
  logic [ROWS-1:0] row_n;
  logic            col_oe;
  logic [COLS-1:0] col_drive;
  logic [COLS-1:0] col_lvl;
  logic [NB-1:0]   snap;
  logic            frame_done;

  always #4 clk = ~clk;

  opto_matrix_scanner #(
    .ROWS(ROWS), .COLS(COLS), .PRECHARGE_CYC(PRE), .SETTLE_CYC(SET)
  ) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .row_n_o(row_n),
    .col_oe_o(col_oe), .col_drive_o(col_drive), .col_i(col_lvl),
    .snap_o(snap), .frame_done_o(frame_done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Matrix model: which opto conducts, and the frame the bench expects.
  logic [COLS-1:0] press [ROWS];
  int frame_no = 0;

  function automatic logic [NB-1:0] pack_expected();
    logic [NB-1:0] v = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        v[r*COLS + c] = press[r][c];
    return v;
  endfunction

  task automatic pick_pattern(input int k);
    for (int r = 0; r < ROWS; r++) begin
      case (k)
        0: press[r] = '0;
        1: press[r] = '1;
        2: press[r] = (r == 0) ? COLS'(1) : '0;
        3: press[r] = (r == ROWS-1) ? COLS'(1) << (COLS-1) : '0;
        4: press[r] = COLS'(1);
        default: press[r] = COLS'($urandom);
      endcase
    end
  endtask

  // Column nodes keep their level: an opto pulls low only after a full
  // settle interval, and only a precharge lifts the node again.
  int runlen [ROWS];

  // Protocol monitor state.
  logic [ROWS-1:0] prev_rows;
  logic            prev_oe;
  logic            prev_done;
  logic [NB-1:0]   prev_snap;
  int  oe_run, act_run, act_row, act_expect, rows_in_frame;
  bit  pc_good, after_abort;

  function automatic int low_index(input logic [ROWS-1:0] v);
    for (int r = 0; r < ROWS; r++) if (!v[r]) return r;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) runlen[r] = 0;
      col_lvl = '1;
    end else begin
      for (int r = 0; r < ROWS; r++) runlen[r] = row_n[r] ? 0 : runlen[r] + 1;
      if (col_oe) col_lvl = col_drive;
      else
        for (int r = 0; r < ROWS; r++)
          if (runlen[r] >= SET) col_lvl = col_lvl & ~press[r];
    end

    if (rst_n) begin
      chk($countones(~row_n) <= 1, "R2 one row low", 64'(row_n), '1);
      if (col_oe) begin
        chk(&row_n, "R2 rows free while columns driven", 64'(row_n), '1);
        chk(&col_drive, "R3 precharge drives ones", 64'(col_drive), '1);
      end
      if (!prev_done)
        chk(snap == prev_snap || frame_done, "R6 snapshot changed without strobe",
            64'(snap), 64'(prev_snap));

      if (!scan_en) begin
        chk((&row_n) && !col_oe, "R7 released while disabled",
            64'({col_oe, row_n}), 64'({1'b0, {ROWS{1'b1}}}));
        chk(!frame_done || prev_rows == '1 || rows_in_frame == ROWS-1,
            "R7 aborted frame strobe", 64'(frame_done), 0);
        oe_run = 0; act_run = 0; act_expect = 0; rows_in_frame = 0;
        pc_good = 0; after_abort = 1;
      end else begin
        // precharge window
        if (col_oe && !prev_oe) begin
          chk(prev_rows == '1, "R3 release before precharge", 64'(prev_rows), '1);
          oe_run = 1;
        end else if (col_oe) begin
          oe_run++;
        end else if (prev_oe) begin
          chk(oe_run == PRE, "R3 precharge length", 64'(oe_run), 64'(PRE));
          chk(&row_n, "R3 turnaround cycle rows free", 64'(row_n), '1);
          pc_good = (oe_run == PRE);
          oe_run = 0;
        end
        // row activity
        if (row_n != '1 && prev_rows == '1) begin
          chk(pc_good && !prev_oe, "R3 precharge and turnaround before row",
              64'(pc_good), 1);
          if (after_abort)
            chk(low_index(row_n) == 0, "R7 restart at row 0",
                64'(low_index(row_n)), 0);
          chk(low_index(row_n) == act_expect, "R4 row order",
              64'(low_index(row_n)), 64'(act_expect));
          act_row = low_index(row_n); act_run = 1; pc_good = 0; after_abort = 0;
        end else if (row_n != '1) begin
          chk(row_n == prev_rows, "R3 direct row change", 64'(row_n), 64'(prev_rows));
          act_run++;
        end else if (prev_rows != '1) begin
          chk(act_run == SET, "R4 settle length", 64'(act_run), 64'(SET));
          act_expect = (act_row + 1) % ROWS;
          rows_in_frame++;
        end
      end

      if (frame_done) begin
        chk(!prev_done, "R6 strobe one cycle", 64'(prev_done), 0);
        chk(rows_in_frame == ROWS, "R6 strobe after last row",
            64'(rows_in_frame), 64'(ROWS));
        chk(snap == pack_expected(), "R5 snapshot content",
            64'(snap), 64'(pack_expected()));
        rows_in_frame = 0;
        frame_no++;
        pick_pattern(frame_no);
      end
    end

    prev_rows = row_n;
    prev_oe   = col_oe;
    prev_done = frame_done;
    prev_snap = snap;
  end

  initial begin
    prev_rows = '1; prev_oe = 0; prev_done = 0; prev_snap = '0;
    oe_run = 0; act_run = 0; act_row = 0; act_expect = 0; rows_in_frame = 0;
    pc_good = 0; after_abort = 1;
    col_lvl = '1;
    void'($urandom(32'h0C7A_5EED));
    pick_pattern(0);
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired frames=%0d", frame_no);
    finish_run();
  end

  initial begin
    logic [NB-1:0] held;
    rst_n   = 1'b0;
    scan_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(row_n == '1, "R1 rows released in reset", 64'(row_n), '1);
    chk(!col_oe && col_drive == '0, "R1 columns input in reset",
        64'({col_oe, col_drive}), 0);
    chk(!frame_done && snap == '0, "R1 strobe and snapshot clear",
        64'({frame_done, snap}), 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(negedge clk);
    chk(row_n == '1 && !col_oe && snap == '0, "R1 state after reset",
        64'({col_oe, row_n}), 64'({1'b0, {ROWS{1'b1}}}));

    // Directed and random frames, with enable drops in mid-frame.
    for (int k = 0; k < 3; k++) begin
      wait (frame_no >= 8 + 8 * k);
      repeat (5 + ($urandom % 20)) @(posedge clk);
      #2 scan_en = 1'b0;
      held = snap;
      #1 chk(row_n == '1 && !col_oe, "R7 same-cycle release",
             64'({col_oe, row_n}), 64'({1'b0, {ROWS{1'b1}}}));
      repeat (3 + ($urandom % 4)) @(posedge clk);
      @(negedge clk);
      chk(snap == held || frame_done, "R7 snapshot kept on abort",
          64'(snap), 64'(held));
      @(posedge clk); #2 scan_en = 1'b1;
    end

    wait (frame_no >= FRAMES_WANTED);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule